// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers hardware interrupt sources into numbered groups of up to four factors each and decides which group, if any, may interrupt the processor. Every group owns one control register. The register holds a 3-bit level shared by all factors of the group, an enable bit and a request bit for each factor, and a read-only detect bit for each factor. A detect bit is the AND of that factor's enable and request bits. A group is active when any of its detect bits is set.

Each cycle the controller compares every active group against the processor's 3-bit mask level. A smaller level value means a more urgent group. Among the eligible groups, the one with the smallest level is chosen. When levels are equal, the smaller group number is chosen. The interrupt line, the winning group number and its level come out of registers.

Software reaches the registers through a group index, a write strobe and write data. Read data is registered. A write changes a request bit only where the detect field of the write data holds a 1. Group 0 uses write-one-to-clear on that same detect field. Groups with no implemented factors are tied off.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset, every level, enable and request field is 0, `irq` is 0, `acc_group` and `acc_level` are 0, and every register reads 0.
- R2: A one-cycle pulse on `src_pulse[g*4+f]` sets the request bit of factor f in group g at the next clock edge.
- R3: Register layout: bits [3:0] hold the request bits, [7:4] the enable bits, [11:8] the detect bits (enable AND request, read-only), [14:12] the level, and bit 15 reads 0. `rd_data` shows the group selected by `reg_sel` one clock after it is sampled.
- R4: In groups 2 and up, a write sets request bit f to write-data bit f only when write-data bit 8+f is 1. Otherwise the request bit keeps its value, whatever the written request field holds.
- R5: In group 0, writing 1 to detect bit 8+f clears request f. Writing 0 there leaves request f unchanged. The written request field has no effect.
- R6: If a hardware pulse and a software write hit the same request bit in the same cycle, the bit ends up at 1.
- R7: A group can only be accepted when its level is numerically smaller than `cpu_mask`. A mask of 0 blocks every group.
- R8: Among eligible active groups, the one with the smallest level value is accepted.
- R9: Among eligible active groups with equal levels, the lowest group number is accepted.
- R10: `irq`, `acc_group` and `acc_level` are registered. They follow register state and `cpu_mask` one clock later. When no group is eligible, all three are 0.
- R11: Level and enable fields take the written values on every write to an implemented group.
- R12: Group 1 has no factors. It reads 0, ignores writes and its pulses, and is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 80 | Hardware set pulses, bit g*4+f for factor f of group g |
| cpu_mask | input | 3 | Processor mask level; a group needs a level below it |
| reg_sel | input | 5 | Group register index for read and write |
| wr_en | input | 1 | Write strobe for the selected group register |
| wr_data | input | 16 | Write data in the register layout of R3 |
| rd_data | output | 16 | Registered read data of the selected group |
| irq | output | 1 | Interrupt request to the processor |
| acc_group | output | 5 | Number of the accepted group |
| acc_level | output | 3 | Level of the accepted group |

## Verification
The per-factor write assertions apply only when no hardware pulse reaches the same bit in that cycle. They also expect `reg_sel` to stay below the group count whenever `wr_en` is high. The bench drives pulses and writes separately except in the single collision scenario, where the required outcome is simply 1. It only selects existing group indices. The output assertions assume `cpu_mask` is an ordinary input sampled at the clock. The bench changes it only on falling edges.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

  localparam int LVL_W  = 3;
  localparam int FACT_N = 4;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic active;
    lvl_t lvl;
  } grp_stat_t;

endpackage

// File: rtl/gpic_group.sv
module gpic_group
  import gpic_pkg::*;
#(
  parameter int FN       = FACT_N,
  parameter int DW       = 3 * FACT_N + LVL_W + 1,
  parameter bit CLR_MODE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [FN-1:0] src,
  output logic [DW-1:0] rdata,
  output grp_stat_t     stat
);

  localparam int REQ_LSB = 0;
  localparam int EN_LSB  = FN;
  localparam int DET_LSB = 2 * FN;
  localparam int LVL_LSB = 3 * FN;

  logic [FN-1:0] req_q, en_q, det, wreq, wen, wdet, req_sw, req_d;
  lvl_t          lvl_q, wlvl;

  assign wreq = wdata[REQ_LSB +: FN];
  assign wen  = wdata[EN_LSB  +: FN];
  assign wdet = wdata[DET_LSB +: FN];
  assign wlvl = wdata[LVL_LSB +: LVL_W];

  generate
    if (CLR_MODE) begin : g_clr
      assign req_sw = wr ? (req_q & ~wdet) : req_q;
    end else begin : g_sel
      assign req_sw = wr ? ((req_q & ~wdet) | (wreq & wdet)) : req_q;
    end
  endgenerate

  assign req_d = req_sw | src;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      en_q  <= '0;
      lvl_q <= '0;
    end else begin
      req_q <= req_d;
      if (wr) begin
        en_q  <= wen;
        lvl_q <= wlvl;
      end
    end
  end

  assign det = req_q & en_q;

  always_comb begin
    rdata                    = '0;
    rdata[REQ_LSB +: FN]     = req_q;
    rdata[EN_LSB  +: FN]     = en_q;
    rdata[DET_LSB +: FN]     = det;
    rdata[LVL_LSB +: LVL_W]  = lvl_q;
  end

  assign stat.active = |det;
  assign stat.lvl    = lvl_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_q == '0 && en_q == '0 && lvl_q == '0));

  generate
    for (genvar f = 0; f < FN; f++) begin : g_chk
      // R2
      pulse_sets_chk: assert property (@(posedge clk) disable iff (rst)
        src[f] |=> req_q[f]);
      // R4 R5
      nodet_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdet[f] && !src[f]) |=> $stable(req_q[f]));
      if (CLR_MODE) begin : g_c
        // R5
        w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
          (wr && wdet[f] && !src[f]) |=> !req_q[f]);
      end else begin : g_s
        // R4
        det_load_chk: assert property (@(posedge clk) disable iff (rst)
          (wr && wdet[f] && !src[f]) |=> (req_q[f] == $past(wreq[f])));
      end
    end
  endgenerate

endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter
  import gpic_pkg::*;
#(
  parameter int GN = 20,
  parameter int GW = (GN > 1) ? $clog2(GN) : 1
) (
  input  grp_stat_t        stat [GN],
  input  lvl_t             mask,
  output logic             found,
  output logic [GW-1:0]    gidx,
  output lvl_t             glvl
);

  logic [GN-1:0] elig;

  generate
    for (genvar g = 0; g < GN; g++) begin : g_elig
      assign elig[g] = stat[g].active && (stat[g].lvl < mask);
    end
  endgenerate

  // Scan from the top group downward; "<=" lets a lower index displace an
  // equal level, so ties settle on the smallest group number.
  always_comb begin
    found = 1'b0;
    gidx  = '0;
    glvl  = '0;
    for (int g = GN - 1; g >= 0; g--) begin
      if (elig[g] && (!found || stat[g].lvl <= glvl)) begin
        found = 1'b1;
        gidx  = GW'(g);
        glvl  = stat[g].lvl;
      end
    end
  end

endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import gpic_pkg::*;
#(
  parameter int          GROUP_N       = 20,
  parameter logic [19:0] GROUP_PRESENT = 20'hFFFFD,
  parameter int          GIDX_W        = $clog2(GROUP_N),
  parameter int          SRC_W         = GROUP_N * FACT_N,
  parameter int          DATA_W        = 3 * FACT_N + LVL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  src_pulse,
  input  logic [LVL_W-1:0]  cpu_mask,
  input  logic [GIDX_W-1:0] reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic [GIDX_W-1:0] acc_group,
  output logic [LVL_W-1:0]  acc_level
);

  grp_stat_t         stat   [GROUP_N];
  logic [DATA_W-1:0] rd_arr [GROUP_N];

  generate
    for (genvar g = 0; g < GROUP_N; g++) begin : g_grp
      if (GROUP_PRESENT[g]) begin : g_on
        gpic_group #(
          .FN      (FACT_N),
          .DW      (DATA_W),
          .CLR_MODE(g == 0)
        ) u_grp (
          .clk  (clk),
          .rst  (rst),
          .wr   (wr_en && (reg_sel == GIDX_W'(g))),
          .wdata(wr_data),
          .src  (src_pulse[g*FACT_N +: FACT_N]),
          .rdata(rd_arr[g]),
          .stat (stat[g])
        );
      end else begin : g_off
        assign rd_arr[g] = '0;
        assign stat[g]   = '0;
      end
    end
  endgenerate

  logic              arb_found;
  logic [GIDX_W-1:0] arb_idx;
  lvl_t              arb_lvl;

  gpic_arbiter #(
    .GN(GROUP_N),
    .GW(GIDX_W)
  ) u_arb (
    .stat (stat),
    .mask (cpu_mask),
    .found(arb_found),
    .gidx (arb_idx),
    .glvl (arb_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      acc_group <= '0;
      acc_level <= '0;
      rd_data   <= '0;
    end else begin
      irq       <= arb_found;
      acc_group <= arb_idx;
      acc_level <= arb_lvl;
      rd_data   <= (int'(reg_sel) < GROUP_N) ? rd_arr[reg_sel] : '0;
    end
  end

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (acc_level < $past(cpu_mask)));
  // R12
  empty_never_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> GROUP_PRESENT[acc_group]);
  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (acc_group == '0 && acc_level == '0));
  // R7
  zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_mask) == '0) |-> !irq);

endmodule

// File: tb/grp_irq_ctrl_test.sv
module grp_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [79:0] src_pulse;
  logic [2:0]  cpu_mask;
  logic [4:0]  reg_sel;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        irq;
  logic [4:0]  acc_group;
  logic [2:0]  acc_level;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  grp_irq_ctrl uut (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .cpu_mask(cpu_mask),
    .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq(irq), .acc_group(acc_group), .acc_level(acc_level)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int g, input logic [15:0] d);
    @(negedge clk);
    reg_sel = 5'(g); wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    src_pulse[idx] = 1'b1;
    @(posedge clk); #1;
    src_pulse = '0;
  endtask

  task automatic rd_chk(input string tag, input int g, input int exp);
    @(negedge clk);
    reg_sel = 5'(g);
    @(posedge clk); #1;
    check(tag, int'(rd_data), exp);
  endtask

  task automatic out_chk(input string tag, input int i, input int g, input int l);
    @(posedge clk); #1;
    check({tag, " irq"}, int'(irq), i);
    check({tag, " group"}, int'(acc_group), g);
    check({tag, " level"}, int'(acc_level), l);
  endtask

  task automatic t_reset;
    check("R1 irq", int'(irq), 0);
    check("R1 group", int'(acc_group), 0);
    check("R1 level", int'(acc_level), 0);
    rd_chk("R1 read g0", 0, 0);
    rd_chk("R1 read g7", 7, 0);
  endtask

  task automatic t_fields;
    wr(3, 16'h2030);
    rd_chk("R11 lvl/en g3", 3, 16'h2030);
    out_chk("R10 no request", 0, 0, 0);
  endtask

  task automatic t_pulse;
    pulse(13);
    check("R10 one-cycle latency", int'(irq), 0);
    out_chk("R2 accepted g3", 1, 3, 2);
    rd_chk("R3 detect g3", 3, 16'h2232);
    pulse(14);
    rd_chk("R3 detect needs enable", 3, 16'h2236);
  endtask

  task automatic t_mask;
    @(negedge clk) cpu_mask = 3'd2;
    out_chk("R7 equal mask blocks", 0, 0, 0);
    @(negedge clk) cpu_mask = 3'd3;
    out_chk("R7 mask above level", 1, 3, 2);
    @(negedge clk) cpu_mask = 3'd0;
    out_chk("R7 zero mask", 0, 0, 0);
    @(negedge clk) cpu_mask = 3'd7;
  endtask

  task automatic t_level;
    wr(5, 16'h1010);
    pulse(20);
    out_chk("R8 smaller level wins", 1, 5, 1);
  endtask

  task automatic t_tie;
    wr(2, 16'h1010);
    pulse(8);
    out_chk("R9 tie lower group", 1, 2, 1);
    wr(0, 16'h10F0);
    pulse(0);
    out_chk("R9 tie group 0", 1, 0, 1);
  endtask

  task automatic t_g0;
    pulse(1);
    rd_chk("R5 g0 state", 0, 16'h13F3);
    wr(0, 16'h11FF);
    rd_chk("R5 w1c clears one", 0, 16'h12F2);
    wr(0, 16'h10FF);
    rd_chk("R5 zero detect keeps", 0, 16'h12F2);
    wr(0, 16'h12F0);
    rd_chk("R5 w1c clears last", 0, 16'h10F0);
    out_chk("R9 g2 after g0 idle", 1, 2, 1);
  endtask

  task automatic t_sel;
    wr(3, 16'h2230);
    rd_chk("R4 selected bit loaded", 3, 16'h2034);
    wr(3, 16'h2038);
    rd_chk("R4 request ignored w/o detect", 3, 16'h2034);
    wr(3, 16'h2838);
    rd_chk("R4 selected bit set", 3, 16'h203C);
  endtask

  task automatic t_collide;
    @(negedge clk);
    reg_sel = 5'd3; wr_data = 16'h2130; wr_en = 1'b1; src_pulse[12] = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; src_pulse = '0;
    rd_chk("R6 hardware wins", 3, 16'h213D);
  endtask

  task automatic t_empty;
    pulse(4); pulse(5); pulse(6); pulse(7);
    wr(1, 16'h0FFF);
    rd_chk("R12 group1 reads 0", 1, 0);
    out_chk("R12 group1 not accepted", 1, 2, 1);
  endtask

  task automatic t_idle;
    wr(2, 16'h1110);
    wr(5, 16'h1110);
    wr(3, 16'h2D30);
    out_chk("R10 idle outputs zero", 0, 0, 0);
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; src_pulse = '0; cpu_mask = 3'd7; reg_sel = '0;
    wr_en = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    t_reset();
    t_fields();
    t_pulse();
    t_mask();
    t_level();
    t_tie();
    t_g0();
    t_sel();
    t_collide();
    t_empty();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule